// File: doc/BRIEF.md
# Two-Port Collision Detector and Transmit Arbiter

This block sits between two DTE transmit receivers and the shared transmit path toward a MAU. Each cycle of a 40 MHz sampling clock it looks at three qualified activity flags: one per DTE port and one for the MAU collision pair. It decides whether a collision exists and which DTE stream feeds the shared transmit output. While a collision lasts, it drives a gated 10 MHz square wave toward the collision pairs of both DTE ports.

A collision is either of two things. One is two eligible DTE ports active together. The other is an active MAU collision flag while the SQE-test gap flag is low. A port that the jabber logic has disabled is dropped from both the transmit path and the local collision check. Port 1 always wins the transmit path. The selection moves between ports in the middle of a collision as port 1 joins or leaves. The collision indication rises one clock after the condition appears. It is held for a fixed hang time after the condition clears, which places the turn-off inside the 2 to 5 bit-time window.

Top module: `dte_collision_arbiter`

## Requirements
- R1: While reset is asserted, tx_en, tx_sel, col_en and osc_wave are all 0.
- R2: tx_en is 1 after a rising edge at which at least one port was eligible, and 0 after an edge at which none was. A port is eligible when its activity flag is 1 and its jabber flag is 0.
- R3: After an edge at which port 1 is eligible, tx_sel is 0 (port 1), whether or not port 2 is eligible. After an edge at which only port 2 is eligible, tx_sel is 1 (port 2). This includes switching in either direction during a collision.
- R4: After an edge at which no port is eligible, tx_sel keeps its previous value.
- R5: A port whose jabber flag is 1 cannot set tx_en, cannot be selected, and does not count toward a local collision.
- R6: When both ports are eligible at a rising edge, both col_en bits are 1 after that edge.
- R7: mau_col at 1 raises col_en after the edge that samples it, but only while sqe_gap is 0. With sqe_gap at 1, mau_col has no effect on col_en.
- R8: Once the collision condition clears, col_en stays 1 and falls at the HANG_CYCLES-th rising edge, counting the first edge that samples the condition false as edge 1. With the default of 12, that is 300 ns.
- R9: osc_wave is 0 whenever col_en is 0. From activation it reads 0,0,1,1,0,0,1,1,… one value per clock, toggling every HALF_PERIOD clocks. At the default of 2 this is a 10 MHz, 50% duty wave.
- R10: Both col_en bits are always equal: a collision is signalled on both DTE ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_a | input | 1 | DTE port 1 unsquelched activity |
| act_b | input | 1 | DTE port 2 unsquelched activity |
| jab_a | input | 1 | DTE port 1 held in jabber state |
| jab_b | input | 1 | DTE port 2 held in jabber state |
| mau_col | input | 1 | MAU collision pair active |
| sqe_gap | input | 1 | SQE-test gap window is open |
| tx_en | output | 1 | Shared transmit output enabled |
| tx_sel | output | 1 | Transmit source: 0 port 1, 1 port 2 |
| col_en | output | 2 | Collision enable per DTE port (bit 0 port 1) |
| osc_wave | output | 1 | Gated collision square wave |

## Verification
The bench starts port 2, then adds port 1 and removes it again. A design with a sticky or inverted priority would leave the source on the wrong port, and one that reset the selection on idle would lose the held value. It counts the exact edge at which the collision indication falls after the condition clears, which catches a hang counter that is off by one or reloads at the wrong moment. It checks the oscillator phase value by value from activation, so a wrong divider or a free-running phase shows up. It also drives the MAU collision flag inside the SQE gap and a jabbered port against an active one. A design that ignored the gap or let a jabbered port through would raise a false collision or drive the wrong source.

// File: rtl/col_pkg.sv
package col_pkg;
  // Transmit source encoding on tx_sel
  typedef enum logic {
    SRC_P1 = 1'b0,
    SRC_P2 = 1'b1
  } src_sel_e;

  localparam int unsigned NUM_DTE = 2;
endpackage

// File: rtl/col_src_arbiter.sv
module col_src_arbiter
  import col_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic elig_a,
  input  logic elig_b,
  output logic tx_en,
  output logic tx_sel
);
  src_sel_e sel_q, sel_d;
  logic     en_q, en_d;

  always_comb begin
    sel_d = sel_q;
    en_d  = elig_a | elig_b;
    if (elig_a)      sel_d = SRC_P1;   // port 1 has fixed priority
    else if (elig_b) sel_d = SRC_P2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SRC_P1;
      en_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      en_q  <= en_d;
    end
  end

  assign tx_en  = en_q;
  assign tx_sel = sel_q;
endmodule

// File: rtl/col_hang_timer.sv
module col_hang_timer #(
  parameter int unsigned HANG_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic active
);
  localparam int unsigned CNT_W = $clog2(HANG_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cond)
      cnt_d = CNT_W'(HANG_CYCLES);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/col_square_osc.sv
module col_square_osc #(
  parameter int unsigned HALF_PERIOD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic wave
);
  localparam int unsigned DIV_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_PERIOD - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             wave_q, wave_d;
  logic             div_wrap;

  assign div_wrap = (div_q == DIV_LAST);

  always_comb begin
    div_d  = div_q;
    wave_d = wave_q;
    if (!run) begin
      div_d  = '0;
      wave_d = 1'b0;
    end else if (div_wrap) begin
      div_d  = '0;
      wave_d = ~wave_q;
    end else begin
      div_d  = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      wave_q <= wave_d;
    end
  end

  assign wave = wave_q & run;
endmodule

// File: rtl/dte_collision_arbiter.sv
module dte_collision_arbiter
  import col_pkg::*;
#(
  parameter int unsigned HANG_CYCLES = 12,
  parameter int unsigned HALF_PERIOD = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               act_a,
  input  logic               act_b,
  input  logic               jab_a,
  input  logic               jab_b,
  input  logic               mau_col,
  input  logic               sqe_gap,
  output logic               tx_en,
  output logic               tx_sel,
  output logic [NUM_DTE-1:0] col_en,
  output logic               osc_wave
);
  logic elig_a, elig_b;
  logic local_col, mau_valid, col_cond;
  logic col_active;

  assign elig_a    = act_a & ~jab_a;
  assign elig_b    = act_b & ~jab_b;
  assign local_col = elig_a & elig_b;
  assign mau_valid = mau_col & ~sqe_gap;
  assign col_cond  = local_col | mau_valid;

  col_src_arbiter i_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .elig_a (elig_a),
    .elig_b (elig_b),
    .tx_en  (tx_en),
    .tx_sel (tx_sel)
  );

  col_hang_timer #(.HANG_CYCLES(HANG_CYCLES)) i_hang (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond   (col_cond),
    .active (col_active)
  );

  col_square_osc #(.HALF_PERIOD(HALF_PERIOD)) i_osc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (col_active),
    .wave  (osc_wave)
  );

  for (genvar p = 0; p < NUM_DTE; p++) begin : g_col_fan
    assign col_en[p] = col_active;
  end
endmodule

// File: rtl/dte_collision_arbiter_chk.sv
module dte_collision_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       act_a,
  input logic       act_b,
  input logic       jab_a,
  input logic       jab_b,
  input logic       mau_col,
  input logic       sqe_gap,
  input logic       tx_en,
  input logic       tx_sel,
  input logic [1:0] col_en,
  input logic       osc_wave
);
  // R2
  tx_en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_a && !jab_a) || (act_b && !jab_b)) |=> tx_en);

  // R3
  port1_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_a && !jab_a) |=> !tx_sel);

  // R4
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(act_a && !jab_a) && !(act_b && !jab_b)) |=> ($stable(tx_sel) && !tx_en));

  // R6
  local_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_a && !jab_a && act_b && !jab_b) |=> (col_en == 2'b11));

  // R7
  mau_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mau_col && !sqe_gap) |=> col_en[0]);

  // R9
  osc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !col_en[0] |-> !osc_wave);

  // R10
  col_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_en[0] == col_en[1]);
endmodule

bind dte_collision_arbiter dte_collision_arbiter_chk i_chk (.*);

// File: tb/test_dte_collision_arbiter.sv
module test_dte_collision_arbiter;
  localparam int HANG = 12;

  logic       clk, rst_n;
  logic       act_a, act_b, jab_a, jab_b, mau_col, sqe_gap;
  logic       tx_en, tx_sel, osc_wave;
  logic [1:0] col_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  dte_collision_arbiter #(.HANG_CYCLES(HANG), .HALF_PERIOD(2)) i_dte_collision_arbiter (
    .clk(clk), .rst_n(rst_n), .act_a(act_a), .act_b(act_b),
    .jab_a(jab_a), .jab_b(jab_b), .mau_col(mau_col), .sqe_gap(sqe_gap),
    .tx_en(tx_en), .tx_sel(tx_sel), .col_en(col_en), .osc_wave(osc_wave)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    act_a = 0; act_b = 0; jab_a = 0; jab_b = 0; mau_col = 0; sqe_gap = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic t_reset();
    rst_n = 0;
    act_a = 1; act_b = 1; jab_a = 0; jab_b = 0; mau_col = 1; sqe_gap = 0;
    step(); step();
    check("R1 tx_en",  tx_en,  0);
    check("R1 tx_sel", tx_sel, 0);
    check("R1 col_en", col_en, 0);
    check("R1 osc",    osc_wave, 0);
    idle(1);
    rst_n = 1;
    idle(2);
  endtask

  task automatic t_single_hold();
    act_b = 1; step();
    check("R2 tx_en p2",  tx_en, 1);
    check("R3 sel p2",    tx_sel, 1);
    check("R6 no col",    col_en, 0);
    act_b = 0; step();
    check("R2 tx_en off", tx_en, 0);
    check("R4 sel held",  tx_sel, 1);
    step();
    check("R4 sel held 2", tx_sel, 1);
  endtask

  task automatic t_switch_hang();
    act_b = 1; step();
    check("R3 p2 first", tx_sel, 1);
    act_a = 1; step();
    check("R3 switch to p1", tx_sel, 0);
    check("R6 both on", col_en, 3);
    check("R10 pair", col_en[0] == col_en[1], 1);
    act_a = 0; step();   // edge 1 sampling condition false
    check("R3 back to p2", tx_sel, 1);
    check("R8 hang edge1", col_en, 3);
    for (int k = 2; k <= HANG; k++) begin
      step();
      if (k == HANG - 1) check("R8 still on", col_en, 3);
      if (k == HANG)     check("R8 off at edge", col_en, 0);
    end
    check("R2 p2 still tx", tx_en, 1);
    idle(4);
  endtask

  task automatic t_osc();
    mau_col = 1; sqe_gap = 0;
    step();
    check("R7 mau col on", col_en, 3);
    check("R9 phase 0", osc_wave, 0);
    for (int k = 1; k < 10; k++) begin
      step();
      check("R9 phase", osc_wave, (k < 2) ? 0 : ((((k - 2) / 2) % 2 == 0) ? 1 : 0));
    end
    mau_col = 0;
    for (int k = 0; k < HANG; k++) step();
    check("R9 osc off", osc_wave, 0);
    check("R8 col off", col_en, 0);
  endtask

  task automatic t_sqe_gap();
    mau_col = 1; sqe_gap = 1;
    step(); step(); step();
    check("R7 gap ignores mau", col_en, 0);
    check("R7 gap osc", osc_wave, 0);
    sqe_gap = 0; step();
    check("R7 gap closed", col_en, 3);
    idle(HANG + 2);
  endtask

  task automatic t_jabber();
    act_a = 1; jab_a = 1; act_b = 1; step();
    check("R5 jab p1 sel", tx_sel, 1);
    check("R5 jab no col", col_en, 0);
    check("R5 p2 tx", tx_en, 1);
    act_b = 0; step();
    check("R5 jab p1 no tx", tx_en, 0);
    jab_a = 0; jab_b = 1; act_b = 1; step();
    check("R5 jab p2 sel", tx_sel, 0);
    check("R5 jab p2 no col", col_en, 0);
    idle(2);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_single_hold();
    t_switch_hang();
    t_osc();
    t_sqe_gap();
    t_jabber();
    report();
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule